// File: doc/BRIEF.md
# Wireless Receive Frame Filter

This block classifies each received 802.11 frame from its already parsed header and decides whether the frame should be discarded. The parser presents the low ten bits of frame control and the three header addresses. It holds them stable while the frame is being received. When the frame ends, the receive path pulses `eof_valid` together with the CRC error, PHY error and OFDM indications. Exactly one clock later the filter issues a single-cycle result strobe. The strobe carries a drop decision and a set of classification flags that the receive path writes into the frame's status word.

Station address, BSSID, the BSS mode, a unicast-to-me byte mask, a global receive disable and nine per-class drop enables are static configuration inputs. The BSS mode masks low bits of the last BSSID byte, so one comparator accepts one, two or four BSSIDs. The unicast-to-me test on the last station address byte uses that same mask ANDed with the separate unicast mask.

Addresses are packed with byte 0, the first byte on air, in bits [7:0] and byte 5 in bits [47:40].

Top module: `wlan_rx_filter`

## Requirements
- R1: `res_valid` is high for exactly the one cycle that follows a cycle with `eof_valid` high. It is low in every other cycle.
- R2: Address 1 all ones sets `res_bcast`. Address 1 with bit 0 set (the group bit) and not all ones sets `res_mcast`. The two flags are never set together.
- R3: `bss_mode` selects which bits of BSSID byte 5 (bits [47:40]) take no part in the my-BSS comparison. Mode 0 ignores none, mode 1 ignores bit 0, mode 2 ignores bit 1, and mode 3 ignores bits 0 and 1. All other bits of the BSSID must be equal for `res_my_bss`.
- R4: The BSSID is taken from `fc[9:8]`, with bit 8 the to-DS bit and bit 9 the from-DS bit. When both are 0 it comes from address 3. When from-DS is 1 and to-DS is 0 it comes from address 2. When to-DS is 1 and from-DS is 0 it comes from address 1. When both are 1, `res_my_bss` is 0.
- R5: `res_ucast_me` is set when address 1 has its group bit clear and matches `sta_addr`. Bytes 0 to 4 must match exactly. Byte 5 is compared only on the bits set in (BSS mode mask AND `ucast_mask`).
- R6: Each drop class has its own enable bit. The bits are 0 CRC error, 1 PHY error, 2 version error, 3 control frame, 4 ACK/CTS, 5 to-DS set, 6 unicast not to me, 7 multicast, and 8 broadcast. A frame is dropped when any enabled class applies.
- R7: The frame control fields are decoded as follows. Bits [1:0] are the protocol version, and any nonzero value is a version error. Bits [3:2] are the type, and value 1 means a control frame. Bits [7:4] are the subtype. A control frame with subtype 13 (ACK) or 12 (CTS) is ACK/CTS.
- R8: With `rx_disable` high every frame is reported with `res_drop` set, whatever the enables.
- R9: `res_crc_err` and `res_ofdm` repeat `eof_crc_err` and `eof_ofdm`. A CRC or PHY error drops the frame only when its enable bit is set.
- R10: After reset `res_valid` and all result flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_fc | input | 10 | Frame control bits [9:0] |
| hdr_addr1 | input | 48 | Address 1 (receiver) |
| hdr_addr2 | input | 48 | Address 2 (transmitter) |
| hdr_addr3 | input | 48 | Address 3 |
| eof_valid | input | 1 | End of frame, one cycle |
| eof_crc_err | input | 1 | Frame failed its CRC |
| eof_phy_err | input | 1 | PHY reported an error |
| eof_ofdm | input | 1 | Frame received with OFDM modulation |
| sta_addr | input | 48 | Own station address |
| bssid | input | 48 | BSSID base address |
| bss_mode | input | 2 | Number of BSSIDs mode (R3) |
| ucast_mask | input | 8 | Byte 5 unicast-to-me mask |
| rx_disable | input | 1 | Drop every frame |
| drop_en | input | 9 | Per-class drop enables (R6) |
| res_valid | output | 1 | Result strobe |
| res_drop | output | 1 | Frame is to be discarded |
| res_ucast_me | output | 1 | Unicast addressed to this station |
| res_mcast | output | 1 | Multicast |
| res_bcast | output | 1 | Broadcast |
| res_my_bss | output | 1 | BSSID matches |
| res_crc_err | output | 1 | CRC error flag |
| res_ofdm | output | 1 | OFDM flag |

## Verification
The BSSID comparator is swept over every value of the last address byte in all four BSS modes. This separates each ignored bit from each compared one. The unicast-to-me match is swept the same way under several unicast masks, which shows that the effective mask is the AND of the two masks and not either mask alone. The low frame control byte is swept through all 256 values with each drop enable set on its own, which isolates version, type, subtype and to-DS decoding per class. Directed frames then cover the four distribution-system combinations, broadcast against multicast against unicast, the CRC and PHY enables, and the global disable.

// File: rtl/wrxf_pkg.sv
package wrxf_pkg;

    localparam int OCTET_W      = 8;
    localparam int DROP_CLASSES = 9;
    localparam int FC_W         = 10;

    // Bit positions inside the drop enable vector
    localparam int DC_CRC     = 0;
    localparam int DC_PHY     = 1;
    localparam int DC_VERSION = 2;
    localparam int DC_CONTROL = 3;
    localparam int DC_ACKCTS  = 4;
    localparam int DC_TODS    = 5;
    localparam int DC_NOTME   = 6;
    localparam int DC_MCAST   = 7;
    localparam int DC_BCAST   = 8;

    localparam logic [1:0] FT_CONTROL = 2'd1;
    localparam logic [3:0] ST_CTS     = 4'd12;
    localparam logic [3:0] ST_ACK     = 4'd13;

    typedef enum logic [1:0] {
        DS_NONE = 2'b00,  // {from, to}
        DS_TO   = 2'b01,
        DS_FROM = 2'b10,
        DS_WDS  = 2'b11
    } ds_dir_e;

    typedef struct packed {
        logic    ver_err;
        logic    is_ctrl;
        logic    is_ackcts;
        logic    to_ds;
        ds_dir_e dir;
    } fc_info_t;

    typedef struct packed {
        logic group;
        logic bcast;
        logic ucast_me;
        logic my_bss;
    } addr_class_t;

    typedef struct packed {
        logic drop;
        logic ucast_me;
        logic mcast;
        logic bcast;
        logic my_bss;
        logic crc_err;
        logic ofdm;
    } rx_result_t;

    // Compare mask on byte 5 of the BSSID: a set bit takes part
    function automatic logic [OCTET_W-1:0] bss_cmp_mask(input logic [1:0] mode);
        logic [OCTET_W-1:0] m;
        m = '1;
        m[1:0] = ~mode;
        return m;
    endfunction

endpackage

// File: rtl/wrxf_fc_decode.sv
module wrxf_fc_decode
    import wrxf_pkg::*;
(
    input  logic [FC_W-1:0] fc,
    output fc_info_t        info
);
    logic [1:0] version;
    logic [1:0] ftype;
    logic [3:0] subtype;

    always_comb begin
        version = fc[1:0];
        ftype   = fc[3:2];
        subtype = fc[7:4];
        info.ver_err   = (version != 2'd0);
        info.is_ctrl   = (ftype == FT_CONTROL);
        info.is_ackcts = (ftype == FT_CONTROL) &&
                         ((subtype == ST_ACK) || (subtype == ST_CTS));
        info.to_ds     = fc[8];
        info.dir       = ds_dir_e'({fc[9], fc[8]});
    end
endmodule

// File: rtl/wrxf_addr_match.sv
module wrxf_addr_match
    import wrxf_pkg::*;
#(
    parameter int N_BYTES = 6,
    localparam int ADDR_W = N_BYTES * OCTET_W
) (
    input  logic [ADDR_W-1:0]  addr_a,
    input  logic [ADDR_W-1:0]  addr_b,
    input  logic [OCTET_W-1:0] last_mask,
    output logic               match
);
    logic [N_BYTES-1:0] byte_eq;

    for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
        logic [OCTET_W-1:0] diff;
        assign diff = addr_a[i*OCTET_W +: OCTET_W] ^ addr_b[i*OCTET_W +: OCTET_W];
        if (i == N_BYTES - 1) begin : g_last
            assign byte_eq[i] = ((diff & last_mask) == '0);
        end else begin : g_exact
            assign byte_eq[i] = (diff == '0);
        end
    end

    assign match = &byte_eq;
endmodule

// File: rtl/wrxf_drop_decide.sv
module wrxf_drop_decide
    import wrxf_pkg::*;
(
    input  fc_info_t                info,
    input  addr_class_t             cls,
    input  logic                    crc_err,
    input  logic                    phy_err,
    input  logic                    rx_disable,
    input  logic [DROP_CLASSES-1:0] drop_en,
    output logic                    drop
);
    logic [DROP_CLASSES-1:0] hit;

    always_comb begin
        hit             = '0;
        hit[DC_CRC]     = crc_err;
        hit[DC_PHY]     = phy_err;
        hit[DC_VERSION] = info.ver_err;
        hit[DC_CONTROL] = info.is_ctrl;
        hit[DC_ACKCTS]  = info.is_ackcts;
        hit[DC_TODS]    = info.to_ds;
        hit[DC_NOTME]   = !cls.group && !cls.ucast_me;
        hit[DC_MCAST]   = cls.group && !cls.bcast;
        hit[DC_BCAST]   = cls.bcast;
        drop = rx_disable || (|(hit & drop_en));
    end
endmodule

// File: rtl/wlan_rx_filter.sv
module wlan_rx_filter
    import wrxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W = ADDR_BYTES * OCTET_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [FC_W-1:0]         hdr_fc,
    input  logic [ADDR_W-1:0]       hdr_addr1,
    input  logic [ADDR_W-1:0]       hdr_addr2,
    input  logic [ADDR_W-1:0]       hdr_addr3,
    input  logic                    eof_valid,
    input  logic                    eof_crc_err,
    input  logic                    eof_phy_err,
    input  logic                    eof_ofdm,
    input  logic [ADDR_W-1:0]       sta_addr,
    input  logic [ADDR_W-1:0]       bssid,
    input  logic [1:0]              bss_mode,
    input  logic [OCTET_W-1:0]      ucast_mask,
    input  logic                    rx_disable,
    input  logic [DROP_CLASSES-1:0] drop_en,
    output logic                    res_valid,
    output logic                    res_drop,
    output logic                    res_ucast_me,
    output logic                    res_mcast,
    output logic                    res_bcast,
    output logic                    res_my_bss,
    output logic                    res_crc_err,
    output logic                    res_ofdm
);
    fc_info_t           info;
    addr_class_t        cls;
    logic [ADDR_W-1:0]  frame_bssid;
    logic               bssid_present;
    logic [OCTET_W-1:0] bss_mask;
    logic [OCTET_W-1:0] me_mask;
    logic               bss_eq;
    logic               me_eq;
    logic               drop_now;
    rx_result_t         res_d;
    rx_result_t         res_q;
    logic               valid_q;

    wrxf_fc_decode u_fc (
        .fc   (hdr_fc),
        .info (info)
    );

    // BSSID field position depends on the distribution-system bits
    always_comb begin
        bssid_present = 1'b1;
        unique case (info.dir)
            DS_NONE: frame_bssid = hdr_addr3;
            DS_FROM: frame_bssid = hdr_addr2;
            DS_TO:   frame_bssid = hdr_addr1;
            default: begin
                frame_bssid   = '0;
                bssid_present = 1'b0;
            end
        endcase
    end

    assign bss_mask = bss_cmp_mask(bss_mode);
    assign me_mask  = bss_mask & ucast_mask;

    wrxf_addr_match #(.N_BYTES(ADDR_BYTES)) u_bss_match (
        .addr_a    (frame_bssid),
        .addr_b    (bssid),
        .last_mask (bss_mask),
        .match     (bss_eq)
    );

    wrxf_addr_match #(.N_BYTES(ADDR_BYTES)) u_me_match (
        .addr_a    (hdr_addr1),
        .addr_b    (sta_addr),
        .last_mask (me_mask),
        .match     (me_eq)
    );

    always_comb begin
        cls.group    = hdr_addr1[0];
        cls.bcast    = &hdr_addr1;
        cls.ucast_me = !hdr_addr1[0] && me_eq;
        cls.my_bss   = bssid_present && bss_eq;
    end

    wrxf_drop_decide u_drop (
        .info       (info),
        .cls        (cls),
        .crc_err    (eof_crc_err),
        .phy_err    (eof_phy_err),
        .rx_disable (rx_disable),
        .drop_en    (drop_en),
        .drop       (drop_now)
    );

    always_comb begin
        res_d.drop     = drop_now;
        res_d.ucast_me = cls.ucast_me;
        res_d.mcast    = cls.group && !cls.bcast;
        res_d.bcast    = cls.bcast;
        res_d.my_bss   = cls.my_bss;
        res_d.crc_err  = eof_crc_err;
        res_d.ofdm     = eof_ofdm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= eof_valid;
            if (eof_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign res_valid    = valid_q;
    assign res_drop     = res_q.drop;
    assign res_ucast_me = res_q.ucast_me;
    assign res_mcast    = res_q.mcast;
    assign res_bcast    = res_q.bcast;
    assign res_my_bss   = res_q.my_bss;
    assign res_crc_err  = res_q.crc_err;
    assign res_ofdm     = res_q.ofdm;
endmodule

// File: rtl/wrxf_checker.sv
module wrxf_checker (
    input logic       clk,
    input logic       rst,
    input logic       eof_valid,
    input logic       eof_crc_err,
    input logic       eof_ofdm,
    input logic       rx_disable,
    input logic [8:0] drop_en,
    input logic       res_valid,
    input logic       res_drop,
    input logic       res_ucast_me,
    input logic       res_mcast,
    input logic       res_bcast,
    input logic       res_crc_err,
    input logic       res_ofdm
);
    p_strobe_after_eof_r1: assert property (@(posedge clk) disable iff (rst)
        eof_valid |=> res_valid);

    p_no_strobe_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !eof_valid |=> !res_valid);

    p_group_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !(res_mcast && res_bcast));

    p_me_is_unicast_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ucast_me) |-> (!res_mcast && !res_bcast));

    p_crc_enable_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (eof_valid && eof_crc_err && drop_en[0]) |=> res_drop);

    p_disable_drops_r8: assert property (@(posedge clk) disable iff (rst)
        (eof_valid && rx_disable) |=> res_drop);

    p_flags_follow_r9: assert property (@(posedge clk) disable iff (rst)
        eof_valid |=> (res_crc_err == $past(eof_crc_err)) && (res_ofdm == $past(eof_ofdm)));

    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> !res_valid);
endmodule

bind wlan_rx_filter wrxf_checker u_wrxf_checker (
    .clk          (clk),
    .rst          (rst),
    .eof_valid    (eof_valid),
    .eof_crc_err  (eof_crc_err),
    .eof_ofdm     (eof_ofdm),
    .rx_disable   (rx_disable),
    .drop_en      (drop_en),
    .res_valid    (res_valid),
    .res_drop     (res_drop),
    .res_ucast_me (res_ucast_me),
    .res_mcast    (res_mcast),
    .res_bcast    (res_bcast),
    .res_crc_err  (res_crc_err),
    .res_ofdm     (res_ofdm)
);

// File: tb/wlan_rx_filter_bench.sv
`timescale 1ns/1ps
module wlan_rx_filter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  hdr_fc = '0;
    logic [47:0] hdr_addr1 = '0, hdr_addr2 = '0, hdr_addr3 = '0;
    logic        eof_valid = 1'b0, eof_crc_err = 1'b0, eof_phy_err = 1'b0, eof_ofdm = 1'b0;
    logic [47:0] sta_addr = 48'h5A_44_33_22_11_02;
    logic [47:0] bssid    = 48'hA4_99_88_77_66_00;
    logic [1:0]  bss_mode = 2'd0;
    logic [7:0]  ucast_mask = 8'hFF;
    logic        rx_disable = 1'b0;
    logic [8:0]  drop_en = '0;
    logic        res_valid, res_drop, res_ucast_me, res_mcast, res_bcast;
    logic        res_my_bss, res_crc_err, res_ofdm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    wlan_rx_filter u_wlan_rx_filter (
        .clk(clk), .rst(rst), .hdr_fc(hdr_fc),
        .hdr_addr1(hdr_addr1), .hdr_addr2(hdr_addr2), .hdr_addr3(hdr_addr3),
        .eof_valid(eof_valid), .eof_crc_err(eof_crc_err),
        .eof_phy_err(eof_phy_err), .eof_ofdm(eof_ofdm),
        .sta_addr(sta_addr), .bssid(bssid), .bss_mode(bss_mode),
        .ucast_mask(ucast_mask), .rx_disable(rx_disable), .drop_en(drop_en),
        .res_valid(res_valid), .res_drop(res_drop), .res_ucast_me(res_ucast_me),
        .res_mcast(res_mcast), .res_bcast(res_bcast), .res_my_bss(res_my_bss),
        .res_crc_err(res_crc_err), .res_ofdm(res_ofdm)
    );

    // Expected flags {drop, ucast_me, mcast, bcast, my_bss, crc, ofdm}
    function automatic logic [6:0] expect_flags();
        logic [7:0]  keep_bss, keep_me;
        logic        bc, mc, me, mb, drop, ctl;
        logic [47:0] src;
        keep_bss = 8'hFF - {6'd0, bss_mode};
        keep_me  = keep_bss & ucast_mask;
        bc = (hdr_addr1 == 48'hFFFF_FFFF_FFFF);
        mc = hdr_addr1[0] && !bc;
        me = !hdr_addr1[0] && (hdr_addr1[39:0] == sta_addr[39:0]) &&
             (((hdr_addr1[47:40] ^ sta_addr[47:40]) & keep_me) == 8'd0);
        mb = 1'b1;
        src = hdr_addr3;
        if (hdr_fc[9:8] == 2'b10) src = hdr_addr2;
        else if (hdr_fc[9:8] == 2'b01) src = hdr_addr1;
        else if (hdr_fc[9:8] == 2'b11) mb = 1'b0;
        mb = mb && (src[39:0] == bssid[39:0]) &&
             (((src[47:40] ^ bssid[47:40]) & keep_bss) == 8'd0);
        ctl  = (hdr_fc[3:2] == 2'd1);
        drop = rx_disable
            || (drop_en[0] && eof_crc_err)
            || (drop_en[1] && eof_phy_err)
            || (drop_en[2] && hdr_fc[1:0] != 2'd0)
            || (drop_en[3] && ctl)
            || (drop_en[4] && ctl && (hdr_fc[7:4] == 4'd12 || hdr_fc[7:4] == 4'd13))
            || (drop_en[5] && hdr_fc[8])
            || (drop_en[6] && !hdr_addr1[0] && !me)
            || (drop_en[7] && mc)
            || (drop_en[8] && bc);
        return {drop, me, mc, bc, mb, eof_crc_err, eof_ofdm};
    endfunction

    task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (fc=%h a1=%h mode=%0d umask=%h en=%b)",
                     req, got, exp, hdr_fc, hdr_addr1, bss_mode, ucast_mask, drop_en);
        end
    endtask

    // Present one frame; inputs are set on the falling edge, the strobe is
    // registered at the next rising edge and sampled on the following fall.
    task automatic frame(input string req);
        logic [6:0] exp;
        @(negedge clk);
        eof_valid = 1'b1;
        exp = expect_flags();
        @(negedge clk);
        eof_valid = 1'b0;
        check("R1 strobe", {6'd0, res_valid}, 7'd1);
        check(req, {res_drop, res_ucast_me, res_mcast, res_bcast, res_my_bss,
                    res_crc_err, res_ofdm}, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset", {res_valid, res_drop, res_ucast_me, res_mcast, res_bcast,
                            res_my_bss, res_crc_err}, 7'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle", {6'd0, res_valid}, 7'd0);

        // R3: sweep BSSID byte 5 in every mode
        hdr_fc = 10'h008;
        hdr_addr1 = sta_addr;
        hdr_addr2 = 48'h10_20_30_40_50_60;
        for (int m = 0; m < 4; m++) begin
            bss_mode = m[1:0];
            for (int v = 0; v < 256; v++) begin
                hdr_addr3 = {v[7:0], bssid[39:0]};
                frame("R3 bss mask");
            end
        end
        @(negedge clk);
        check("R1 single cycle", {6'd0, res_valid}, 7'd0);

        // R5: sweep station byte 5 under several unicast masks
        hdr_addr3 = bssid;
        for (int k = 0; k < 4; k++) begin
            ucast_mask = (k == 0) ? 8'hFF : (k == 1) ? 8'hF0 : (k == 2) ? 8'h03 : 8'h00;
            for (int m = 0; m < 4; m++) begin
                bss_mode = m[1:0];
                for (int v = 0; v < 256; v++) begin
                    hdr_addr1 = {v[7:0], sta_addr[39:0]};
                    frame("R5 unicast mask");
                end
            end
        end
        ucast_mask = 8'h00;
        hdr_addr1 = sta_addr ^ 48'h00_00_00_01_00_00;
        frame("R5 exact low bytes");
        ucast_mask = 8'hFF;
        bss_mode = 2'd0;

        // R4: BSSID source per distribution-system bits
        for (int d = 0; d < 4; d++) begin
            for (int s = 0; s < 4; s++) begin
                hdr_fc = {d[1:0], 8'h08};
                hdr_addr1 = (s == 1) ? bssid : sta_addr;
                hdr_addr2 = (s == 2) ? bssid : 48'h10_20_30_40_50_60;
                hdr_addr3 = (s == 3) ? bssid : 48'h0E_0D_0C_0B_0A_08;
                frame("R4 bssid source");
            end
        end

        // R2: address classes
        hdr_fc = 10'h008;
        hdr_addr3 = bssid;
        hdr_addr1 = 48'hFFFF_FFFF_FFFF;            frame("R2 broadcast");
        hdr_addr1 = 48'hFFFF_FFFF_FFFF ^ 48'h2;    frame("R2 multicast near bcast");
        hdr_addr1 = 48'h01_00_5E_00_00_01;         frame("R2 multicast");
        hdr_addr1 = 48'h10_00_5E_00_00_02;         frame("R2 unicast other");

        // R6/R7: every low frame-control value with each enable alone
        for (int e = 0; e < 9; e++) begin
            drop_en = 9'd1 << e;
            for (int f = 0; f < 256; f++) begin
                hdr_fc = {f[1:0], f[7:0]};
                hdr_addr1 = (f % 3 == 0) ? sta_addr :
                            (f % 3 == 1) ? 48'h01_00_5E_00_00_07 : 48'hFFFF_FFFF_FFFF;
                eof_crc_err = f[4];
                eof_phy_err = f[5];
                eof_ofdm    = f[6];
                frame("R6 R7 drop class");
            end
        end

        // R9: error flags with and without their enables
        hdr_fc = 10'h008;
        hdr_addr1 = sta_addr;
        drop_en = '0;
        eof_crc_err = 1'b1; eof_phy_err = 1'b1; eof_ofdm = 1'b1;
        frame("R9 errors not enabled");
        drop_en = 9'b000000010;
        eof_crc_err = 1'b0;
        frame("R9 phy enabled");
        drop_en = 9'b000000001;
        eof_crc_err = 1'b1; eof_phy_err = 1'b0; eof_ofdm = 1'b0;
        frame("R9 crc enabled");

        // R8: global disable overrides everything
        drop_en = '0;
        rx_disable = 1'b1;
        eof_crc_err = 1'b0;
        frame("R8 disable clean frame");
        hdr_addr1 = 48'hFFFF_FFFF_FFFF;
        frame("R8 disable broadcast");
        rx_disable = 1'b0;
        frame("R8 released");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule